// File: doc/BRIEF.md
# Core Power-State Sequencer

This block moves a processor core through three power levels (running, halted and clock-stopped) under two request lines from the surrounding system logic. A halt request closes the instruction fetch gate in the same cycle. The core's in-flight instructions then drain, and the block reports halted once the core says its pipeline is empty. While the core is halted, its functional clock keeps running.

A stop request is honoured only from the halted level. It removes the functional clock enable at once. After a fixed settle window, the block raises the stopped flag. Dropping stop brings the clock back first and clears stopped one cycle later, which returns the core to halted rather than to full operation. Dropping halt while halted resumes fetch. Some request changes are ignored by design: a halt released too early, a stop released while the clock is still settling, and a stop raised outside the halted level.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset the block is fully on: fetch_en=1, clk_en=1, halted=0, stopped=0.
- R2: While fully on, fetch_en is 0 in any cycle where halt_req is 1, with no clock edge in between. Outside the fully-on level, fetch_en stays 0.
- R3: halted rises only on the clock edge after a cycle in which fetch was gated and pipe_empty was 1. The draining state always lasts at least one cycle.
- R4: clk_en stays 1 while draining and while halted. It is 0 only during the settle window and the stopped level.
- R5: When halted (clock running, not stopped) with halt_req=0 and stop_req=0, the next edge returns the block to fully on: halted=0, and fetch_en follows !halt_req.
- R6: Dropping halt_req while draining is ignored. The block still enters halted once pipe_empty is seen.
- R7: stop_req asserted while fully on or draining has no effect and leaves no pending request. If it drops before halted is reached, clk_en stays 1.
- R8: stop_req=1 in the halted level clears clk_en on the next edge. stopped rises after SETTLE_CYCLES (default 2) cycles with clk_en=0.
- R9: Dropping stop_req during the settle window is ignored, and stopped is still reached.
- R10: In the stopped level with stop_req=0, clk_en returns to 1 on the next edge. stopped falls one edge later, and halted stays 1 throughout, so the block is back in the halted level.
- R11: stopped is 1 only while clk_en is 0, except in the single wake cycle that directly follows the stopped level.
- R12: In the halted level, stop_req=1 takes priority over a simultaneous halt_req=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | Request to suspend fetch and halt |
| stop_req | input | 1 | Request to gate the functional clock |
| pipe_empty | input | 1 | Core reports no instructions in flight |
| fetch_en | output | 1 | Instruction fetch allowed |
| clk_en | output | 1 | Functional clock gate enable |
| halted | output | 1 | Core is drained and safe to power down |
| stopped | output | 1 | Functional clock gating is in effect |

## Verification
The bench releases halt in the middle of a drain. A design that honours that release would fall back to fully on and never report halted. It raises stop while the core is running and drops it before halted is reached. A design that latches the request would gate the clock afterwards. It drops stop inside the settle window, where a careless design would abort the gating or skip stopped. It also checks the wake order, in which clk_en must return one cycle before stopped clears and halted must not drop, and it checks that stop wins over a simultaneous halt release.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
   typedef enum logic [2:0] {
      PS_FULL_ON  = 3'd0,
      PS_HALTING  = 3'd1,
      PS_HALTED   = 3'd2,
      PS_STOPPING = 3'd3,
      PS_STOPPED  = 3'd4,
      PS_WAKING   = 3'd5
   } pwr_state_e;
endpackage

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer #(
   parameter int SETTLE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   generate
      if (SETTLE_CYCLES < 1) begin : g_bad_param
         $error("pwr_settle_timer: SETTLE_CYCLES must be at least 1");
      end
      if (SETTLE_CYCLES == 1) begin : g_single
         assign done = run;
      end else begin : g_count
         localparam int CW = $clog2(SETTLE_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (run) cnt_q <= cnt_q + 1'b1;
            else          cnt_q <= '0;
         end
         assign done = run && (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
   import pwr_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_req,
   input  logic       stop_req,
   input  logic       pipe_empty,
   input  logic       settle_done,
   output pwr_state_e state
);
   pwr_state_e state_d;

   always_comb begin
      state_d = state;
      unique case (state)
         PS_FULL_ON:  if (halt_req) state_d = PS_HALTING;
         PS_HALTING:  if (pipe_empty) state_d = PS_HALTED;
         PS_HALTED: begin
            if (stop_req)       state_d = PS_STOPPING;
            else if (!halt_req) state_d = PS_FULL_ON;
         end
         PS_STOPPING: if (settle_done) state_d = PS_STOPPED;
         PS_STOPPED:  if (!stop_req) state_d = PS_WAKING;
         PS_WAKING:   state_d = PS_HALTED;
         default:     state_d = PS_FULL_ON;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_FULL_ON;
      else        state <= state_d;
   end
endmodule

// File: rtl/pwr_seq_outputs.sv
module pwr_seq_outputs
   import pwr_seq_pkg::*;
(
   input  pwr_state_e state,
   input  logic       halt_req,
   output logic       fetch_en,
   output logic       clk_en,
   output logic       halted,
   output logic       stopped,
   output logic       settle_run
);
   always_comb begin
      fetch_en   = (state == PS_FULL_ON) && !halt_req;
      clk_en     = !((state == PS_STOPPING) || (state == PS_STOPPED));
      halted     = (state == PS_HALTED) || (state == PS_STOPPING) ||
                   (state == PS_STOPPED) || (state == PS_WAKING);
      stopped    = (state == PS_STOPPED) || (state == PS_WAKING);
      settle_run = (state == PS_STOPPING);
   end
endmodule

// File: rtl/core_pwr_seq.sv
module core_pwr_seq
   import pwr_seq_pkg::*;
#(
   parameter int SETTLE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_req,
   input  logic stop_req,
   input  logic pipe_empty,
   output logic fetch_en,
   output logic clk_en,
   output logic halted,
   output logic stopped
);
   pwr_state_e state;
   logic       settle_run;
   logic       settle_done;

   pwr_seq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_req   (halt_req),
      .stop_req   (stop_req),
      .pipe_empty (pipe_empty),
      .settle_done(settle_done),
      .state      (state)
   );

   pwr_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (settle_run),
      .done (settle_done)
   );

   pwr_seq_outputs u_out (
      .state     (state),
      .halt_req  (halt_req),
      .fetch_en  (fetch_en),
      .clk_en    (clk_en),
      .halted    (halted),
      .stopped   (stopped),
      .settle_run(settle_run)
   );
endmodule

// File: rtl/core_pwr_seq_chk.sv
module core_pwr_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic halt_req,
   input logic stop_req,
   input logic pipe_empty,
   input logic fetch_en,
   input logic clk_en,
   input logic halted,
   input logic stopped
);
   // R2: fetch gated in the same cycle as a halt request
   assert_fetch_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> !fetch_en);
   assert_no_fetch_when_halted_R2: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !fetch_en);
   // R3: halted follows an observed empty pipeline
   assert_halt_after_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> $past(pipe_empty) && $past(!fetch_en));
   // R4: clock only gated from the halted side
   assert_gate_only_halted_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |-> halted);
   // R5: halt release from plain halted level
   assert_halt_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && clk_en && !stopped && !halt_req && !stop_req) |=> !halted);
   // R8: stop accepted from halted level
   assert_stop_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && clk_en && !stopped && stop_req) |=> !clk_en);
   // R10: wake order
   assert_wake_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_en) && stopped) |=> (!stopped && halted && clk_en));
   // R11: stopped implies gating, apart from the wake cycle
   assert_stopped_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && clk_en) |-> ($past(stopped) && $past(!clk_en)));
endmodule

bind core_pwr_seq core_pwr_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .halt_req  (halt_req),
   .stop_req  (stop_req),
   .pipe_empty(pipe_empty),
   .fetch_en  (fetch_en),
   .clk_en    (clk_en),
   .halted    (halted),
   .stopped   (stopped)
);

// File: tb/tb_core_pwr_seq.sv
module tb_core_pwr_seq;
   localparam int SETTLE = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic halt_req = 1'b0;
   logic stop_req = 1'b0;
   logic pipe_empty = 1'b0;
   logic fetch_en, clk_en, halted, stopped;

   int n_checks = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   // reference model: 0 run, 1 drain, 2 halted, 3 settle, 4 stopped, 5 wake
   int ms = 0;
   int mcnt = 0;

   always #2 clk = ~clk;

   core_pwr_seq #(.SETTLE_CYCLES(SETTLE)) dut (
      .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
      .pipe_empty(pipe_empty), .fetch_en(fetch_en), .clk_en(clk_en),
      .halted(halted), .stopped(stopped)
   );

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
   endtask

   task automatic cmp(string tag);
      logic ef, ec, eh, es;
      ef = (ms == 0) && !halt_req;
      ec = !(ms == 3 || ms == 4);
      eh = (ms >= 2);
      es = (ms == 4 || ms == 5);
      n_checks++;
      if (fetch_en !== ef || clk_en !== ec || halted !== eh || stopped !== es) begin
         n_fail++;
         $display("FAIL %s: fetch/clk/halted/stopped act %b%b%b%b exp %b%b%b%b",
                  tag, fetch_en, clk_en, halted, stopped, ef, ec, eh, es);
      end
   endtask

   task automatic model_step();
      case (ms)
         0: if (halt_req) ms = 1;
         1: if (pipe_empty) ms = 2;
         2: if (stop_req) begin ms = 3; mcnt = 0; end
            else if (!halt_req) ms = 0;
         3: if (mcnt == SETTLE - 1) ms = 4; else mcnt++;
         4: if (!stop_req) ms = 5;
         default: ms = 2;
      endcase
   endtask

   // drive inputs at negedge, compare, then advance model at the edge
   task automatic step(bit h, bit s, bit p, string tag);
      halt_req = h; stop_req = s; pipe_empty = p;
      #1;
      cmp(tag);
      @(posedge clk);
      model_step();
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done_flag) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: act timeout exp completion");
         report();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      step(0, 0, 0, "R1 reset");
      // R2: running, then halt gating fetch immediately
      repeat (3) step(0, 0, 0, "R2 run");
      step(1, 0, 0, "R2 halt gate");
      // R6: halt dropped while draining
      step(0, 0, 0, "R6 early release");
      step(0, 0, 0, "R6 early release");
      // R3: drain completes
      step(0, 0, 1, "R3 drain");
      // R5: halted with halt low returns to run
      step(0, 0, 1, "R5 release");
      step(0, 0, 0, "R5 running");
      // R7: stop outside halted leaves nothing pending
      step(0, 1, 0, "R7 stop in run");
      step(1, 1, 0, "R7 stop in run");
      step(1, 1, 0, "R7 stop while drain");
      step(1, 0, 1, "R7 stop dropped");
      repeat (3) step(1, 0, 1, "R7 no pending R4");
      // R8 and R9: accept stop, drop it during settle
      step(1, 1, 1, "R8 stop accept");
      step(1, 0, 1, "R9 early stop drop");
      step(1, 0, 1, "R9 settle");
      step(1, 0, 1, "R10 wake");
      step(1, 0, 1, "R10 back halted");
      // R8 and R10: full stop hold and release
      step(1, 1, 1, "R8 stop accept");
      repeat (5) step(1, 1, 1, "R8 R11 stopped hold");
      step(1, 0, 1, "R10 stop release");
      step(1, 0, 1, "R10 wake cycle");
      repeat (2) step(1, 0, 1, "R10 halted again R4");
      // R12: stop beats halt release
      step(0, 1, 1, "R12 priority");
      repeat (3) step(0, 1, 0, "R12 stopping");
      step(0, 0, 0, "R10 release to halted");
      step(0, 0, 0, "R10 wake");
      step(0, 0, 0, "R5 release");
      repeat (3) step(0, 0, 0, "R5 R2 run");
      // drain with immediate empty
      step(1, 0, 1, "R3 min drain");
      step(1, 0, 1, "R3 halted");
      step(0, 0, 1, "R5 release");
      step(0, 0, 0, "R1 R2 end run");
      done_flag = 1'b1;
      report();
      $finish;
   end
endmodule